// File: doc/BRIEF.md
# Processor Mailbox Channel Unit

This block carries 32-bit messages between a host processor and an accelerator core through three mailboxes. Two of them run toward the host and hold one word each: a general outbound box and an interrupt box. The third runs toward the core and holds up to four words. The host sees all three through one packed status word. It issues at most one access per cycle on `host_op`. One cycle later it receives a response that carries a success flag, a byte count (4 or 0) and, for reads, the word.

On the core side, each outbound box has a push port and the inbound box has a pop port. The core also sees a channel count for each mailbox: space available in each outbound box, and the number of queued words inbound. Every successful host access raises one event toward the core. The event goes into a pending register and, when the core has the event enabled in its mask, may set a one-bit event channel count. A host access that cannot complete is refused. A refused interrupt-box read or a refused inbound write arms a bit in an 8-bit interrupt mask, so that the host can be woken later.

Each one-entry box is a two-state machine. In `SLOT_EMPTY` a core push moves it to `SLOT_FULL`, and in `SLOT_FULL` a host read returns it to `SLOT_EMPTY`. The inbound box is a three-state machine, `IQ_EMPTY`, `IQ_PARTIAL` and `IQ_FULL`, that follows its word count. A write moves it up from `IQ_EMPTY`, or from `IQ_PARTIAL` to `IQ_FULL`. A pop moves it down from `IQ_FULL`, or from `IQ_PARTIAL` to `IQ_EMPTY`. A write and a pop in the same cycle keep the count and the state unchanged.

Top module: `mbox_channel_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties all three mailboxes and clears the response, the interrupt mask, the pending events and the event count. After reset `host_status` reads 0x00000400.
- R2: `host_status` packs three fields. Bits 7:0 hold the outbound word count (0 or 1). Bits 15:8 hold the free inbound slots. Bits 23:16 hold the interrupt-box word count (0 or 1). Bits 31:24 read zero.
- R3: `host_op` = 1 reads the outbound box. It succeeds only when status bits 7:0 are nonzero. On success the response in the next cycle carries ok=1, bytes=4 and the word, the box empties, and `core_out_space` returns to 1. A refused read gives ok=0, bytes=0, data 0 and changes no state.
- R4: `host_op` = 2 reads the interrupt box under the same rules as R3, using bits 23:16 and `core_int_space`. A refused read also sets `host_irq_mask` bit 0.
- R5: `host_op` = 3 writes `host_wdata` into the inbound box when free space is nonzero. The free field then drops by one and `core_in_count` rises by one. The core pops the words in the order they were written, and `core_in_data` always shows the oldest queued word.
- R6: An inbound write while the free field is 0 is refused (ok=0, bytes=0). It stores nothing and sets `host_irq_mask` bit 4.
- R7: The inbound free field always equals 4 minus `core_in_count`.
- R8: Successful host accesses raise event bits toward the core: an outbound read raises bit 0, an interrupt read raises bit 1, and an inbound write raises bit 2. The raised bit is ORed into `core_ev_pend`. `core_ev_count` becomes 1 only if it was 0, the bit was not already pending, and the bit is set in `core_ev_mask`.
- R9: `core_ev_clr` clears pending bits (write-one-to-clear) and `core_ev_take` clears the event count. A new event raised in the same cycle takes priority over both. `host_mask_clr` clears interrupt mask bits (write-one-to-clear), and a refusal in the same cycle takes priority.
- R10: A core push into a one-entry box is accepted only when the box is empty. It makes the status field read 1 and the box's space output read 0. A push into a full box is ignored and leaves the stored word unchanged.
- R11: An inbound write and a pop in the same cycle both take effect. The count stays the same, and the new word lands behind the words that remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_op | input | 2 | Host access: 0 none, 1 read outbound, 2 read interrupt box, 3 write inbound |
| host_wdata | input | 32 | Word for an inbound write |
| host_mask_clr | input | 8 | Write-one-to-clear for the interrupt mask |
| host_status | output | 32 | Packed mailbox status word |
| host_resp_valid | output | 1 | A response is present (one cycle after an access) |
| host_resp_ok | output | 1 | The access succeeded |
| host_resp_bytes | output | 3 | Bytes transferred: 4 or 0 |
| host_resp_data | output | 32 | Word read, 0 otherwise |
| host_irq_mask | output | 8 | Interrupt mask; bit 0 waits on the interrupt box, bit 4 on inbound space |
| core_out_push | input | 1 | Core pushes into the outbound box |
| core_out_data | input | 32 | Word for the outbound box |
| core_out_space | output | 1 | Outbound channel count: 1 when the box is empty |
| core_int_push | input | 1 | Core pushes into the interrupt box |
| core_int_data | input | 32 | Word for the interrupt box |
| core_int_space | output | 1 | Interrupt channel count: 1 when the box is empty |
| core_in_pop | input | 1 | Core removes the oldest inbound word |
| core_in_data | output | 32 | Oldest inbound word |
| core_in_count | output | 3 | Inbound channel count: queued words |
| core_ev_mask | input | 3 | Event enable mask |
| core_ev_clr | input | 3 | Write-one-to-clear for pending events |
| core_ev_take | input | 1 | Clears the event channel count |
| core_ev_pend | output | 3 | Pending events |
| core_ev_count | output | 1 | Event channel count |

## Verification
The hardest condition to reach is an event that meets all three conditions at once: the event count is 0, the bit is not already pending, and the bit is enabled. Reaching it needs the core to have taken the count and cleared the pending bit before a host access succeeds. The other hard condition is a full inbound box that receives a write and a pop together. The stimulus alternates between write-heavy and pop-heavy phases, so the inbound box repeatedly fills, refuses writes and drains. It also changes the event mask, clears and takes at random, so every combination of the event conditions arises many times. A reference model in the bench predicts every output cycle by cycle.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int FIELD_W = 8;

    typedef enum logic [1:0] {
        HOP_NONE   = 2'd0,
        HOP_RD_OUT = 2'd1,
        HOP_RD_INT = 2'd2,
        HOP_WR_IN  = 2'd3
    } host_op_e;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_e;

    typedef enum logic [1:0] {
        IQ_EMPTY   = 2'd0,
        IQ_PARTIAL = 2'd1,
        IQ_FULL    = 2'd2
    } inq_state_e;

    localparam int EV_OUT_AVAIL  = 0;
    localparam int EV_INT_AVAIL  = 1;
    localparam int EV_IN_WRITTEN = 2;
    localparam int EV_W          = 3;

    localparam int IRQ_INT_WAIT = 0;
    localparam int IRQ_IN_WAIT  = 4;
    localparam int IRQ_W        = 8;
endpackage

// File: rtl/mbox_slot1.sv
module mbox_slot1
    import mbox_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              take,
    output logic              full,
    output logic              take_ok,
    output logic [DATA_W-1:0] data
);
    slot_state_e state_q, state_d;
    logic        push_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SLOT_EMPTY;
            data    <= '0;
        end else begin
            state_q <= state_d;
            if (push_ok) data <= push_data;
        end
    end

    always_comb begin
        state_d = state_q;
        push_ok = 1'b0;
        take_ok = 1'b0;
        unique case (state_q)
            SLOT_EMPTY: begin
                push_ok = push;
                if (push) state_d = SLOT_FULL;
            end
            SLOT_FULL: begin
                take_ok = take;
                if (take) state_d = SLOT_EMPTY;
            end
            default: state_d = SLOT_EMPTY;
        endcase
    end

    assign full = (state_q == SLOT_FULL);

    assert_take_empties_R3: assert property (@(posedge clk) disable iff (rst)
        take_ok |=> !full);
    assert_push_fills_R10: assert property (@(posedge clk) disable iff (rst)
        (push && !full) |=> (full && data == $past(push_data)));
    assert_full_push_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (full && !take) |=> (full && $stable(data)));
endmodule

// File: rtl/mbox_inq.sv
module mbox_inq
    import mbox_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic              wr_ok,
    output logic [CW-1:0]     count,
    output logic [DATA_W-1:0] head
);
    inq_state_e        state_q, state_d;
    logic [CW-1:0]     cnt_d;
    logic [CW-1:0]     base;
    logic              pop_ok;
    logic [DATA_W-1:0] mem [DEPTH];

    always_comb begin
        wr_ok  = 1'b0;
        pop_ok = 1'b0;
        unique case (state_q)
            IQ_EMPTY:   wr_ok = wr;
            IQ_PARTIAL: begin wr_ok = wr; pop_ok = pop; end
            IQ_FULL:    pop_ok = pop;
            default:    ;
        endcase
        cnt_d = count + CW'(wr_ok) - CW'(pop_ok);
        base  = pop_ok ? count - CW'(1) : count;
        if (cnt_d == '0)                state_d = IQ_EMPTY;
        else if (cnt_d == CW'(DEPTH))   state_d = IQ_FULL;
        else                            state_d = IQ_PARTIAL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= IQ_EMPTY;
            count   <= '0;
        end else begin
            state_q <= state_d;
            count   <= cnt_d;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [DATA_W-1:0] shift_in;
        if (i == DEPTH - 1) begin : g_last
            assign shift_in = '0;
        end else begin : g_mid
            assign shift_in = mem[i+1];
        end
        always_ff @(posedge clk) begin
            if (rst)                             mem[i] <= '0;
            else if (wr_ok && base == CW'(i))    mem[i] <= wdata;
            else if (pop_ok)                     mem[i] <= shift_in;
        end
    end

    assign head = mem[0];

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    assert_state_tracks_count_R5: assert property (@(posedge clk) disable iff (rst)
        ((state_q == IQ_FULL) == (count == CW'(DEPTH))) &&
        ((state_q == IQ_EMPTY) == (count == '0)));
    assert_write_grows_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && !pop_ok) |=> count == $past(count) + CW'(1));
    assert_both_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && pop_ok) |=> $stable(count));
endmodule

// File: rtl/mbox_events.sv
module mbox_events
    import mbox_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [EV_W-1:0] raise,
    input  logic [EV_W-1:0] mask,
    input  logic [EV_W-1:0] clr,
    input  logic            take,
    output logic [EV_W-1:0] pend,
    output logic            count
);
    logic fire;

    assign fire = !count && (|(raise & ~pend & mask));

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= '0;
            count <= 1'b0;
        end else begin
            pend <= (pend & ~clr) | raise;
            if (fire)      count <= 1'b1;
            else if (take) count <= 1'b0;
        end
    end

    assert_one_event_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(raise));
    assert_raise_pends_R8: assert property (@(posedge clk) disable iff (rst)
        (raise != '0) |=> ((pend & $past(raise)) == $past(raise)));
    assert_count_rule_R8: assert property (@(posedge clk) disable iff (rst)
        (!count && !take && (raise & (pend | ~mask)) == raise) |=> !count);
endmodule

// File: rtl/mbox_channel_unit.sv
module mbox_channel_unit
    import mbox_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int IN_DEPTH = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [1:0]                      host_op,
    input  logic [DATA_W-1:0]               host_wdata,
    input  logic [7:0]                      host_mask_clr,
    output logic [31:0]                     host_status,
    output logic                            host_resp_valid,
    output logic                            host_resp_ok,
    output logic [2:0]                      host_resp_bytes,
    output logic [DATA_W-1:0]               host_resp_data,
    output logic [7:0]                      host_irq_mask,
    input  logic                            core_out_push,
    input  logic [DATA_W-1:0]               core_out_data,
    output logic                            core_out_space,
    input  logic                            core_int_push,
    input  logic [DATA_W-1:0]               core_int_data,
    output logic                            core_int_space,
    input  logic                            core_in_pop,
    output logic [DATA_W-1:0]               core_in_data,
    output logic [$clog2(IN_DEPTH+1)-1:0]   core_in_count,
    input  logic [2:0]                      core_ev_mask,
    input  logic [2:0]                      core_ev_clr,
    input  logic                            core_ev_take,
    output logic [2:0]                      core_ev_pend,
    output logic                            core_ev_count
);
    localparam int CW = $clog2(IN_DEPTH + 1);

    host_op_e          op;
    logic              out_full, int_full;
    logic              out_take_ok, int_take_ok, in_wr_ok;
    logic [DATA_W-1:0] out_word, int_word;
    logic [EV_W-1:0]   raise;
    logic [FIELD_W-1:0] free_slots;
    logic              refuse_int, refuse_in;

    assign op = host_op_e'(host_op);

    mbox_slot1 #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst(rst), .push(core_out_push), .push_data(core_out_data),
        .take(op == HOP_RD_OUT), .full(out_full), .take_ok(out_take_ok), .data(out_word)
    );

    mbox_slot1 #(.DATA_W(DATA_W)) u_int (
        .clk(clk), .rst(rst), .push(core_int_push), .push_data(core_int_data),
        .take(op == HOP_RD_INT), .full(int_full), .take_ok(int_take_ok), .data(int_word)
    );

    mbox_inq #(.DATA_W(DATA_W), .DEPTH(IN_DEPTH)) u_inq (
        .clk(clk), .rst(rst), .wr(op == HOP_WR_IN), .wdata(host_wdata),
        .pop(core_in_pop), .wr_ok(in_wr_ok), .count(core_in_count), .head(core_in_data)
    );

    always_comb begin
        raise = '0;
        raise[EV_OUT_AVAIL]  = out_take_ok;
        raise[EV_INT_AVAIL]  = int_take_ok;
        raise[EV_IN_WRITTEN] = in_wr_ok;
    end

    mbox_events u_ev (
        .clk(clk), .rst(rst), .raise(raise), .mask(core_ev_mask), .clr(core_ev_clr),
        .take(core_ev_take), .pend(core_ev_pend), .count(core_ev_count)
    );

    assign free_slots     = FIELD_W'(IN_DEPTH) - FIELD_W'(core_in_count);
    assign host_status    = {8'h00, FIELD_W'(int_full), free_slots, FIELD_W'(out_full)};
    assign core_out_space = !out_full;
    assign core_int_space = !int_full;
    assign refuse_int     = (op == HOP_RD_INT) && !int_take_ok;
    assign refuse_in      = (op == HOP_WR_IN) && !in_wr_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            host_resp_valid <= 1'b0;
            host_resp_ok    <= 1'b0;
            host_resp_bytes <= '0;
            host_resp_data  <= '0;
            host_irq_mask   <= '0;
        end else begin
            host_resp_valid <= (op != HOP_NONE);
            host_resp_ok    <= |raise;
            host_resp_bytes <= (|raise) ? 3'd4 : 3'd0;
            unique case (op)
                HOP_RD_OUT: host_resp_data <= out_take_ok ? out_word : '0;
                HOP_RD_INT: host_resp_data <= int_take_ok ? int_word : '0;
                default:    host_resp_data <= '0;
            endcase
            host_irq_mask <= (host_irq_mask & ~host_mask_clr)
                           | (IRQ_W'(refuse_int) << IRQ_INT_WAIT)
                           | (IRQ_W'(refuse_in) << IRQ_IN_WAIT);
        end
    end

    assert_bytes_match_R3: assert property (@(posedge clk) disable iff (rst)
        host_resp_valid |-> (host_resp_bytes == (host_resp_ok ? 3'd4 : 3'd0)));
    assert_int_refuse_arms_R4: assert property (@(posedge clk) disable iff (rst)
        (op == HOP_RD_INT && !int_full) |=> host_irq_mask[IRQ_INT_WAIT]);
    assert_in_refuse_arms_R6: assert property (@(posedge clk) disable iff (rst)
        (op == HOP_WR_IN && free_slots == '0) |=> (host_irq_mask[IRQ_IN_WAIT] && !host_resp_ok));
    assert_free_plus_count_R7: assert property (@(posedge clk) disable iff (rst)
        (32'(free_slots) + 32'(core_in_count)) == 32'(IN_DEPTH));
    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        host_status[31:24] == 8'h00);
    assert_out_read_space_R3: assert property (@(posedge clk) disable iff (rst)
        out_take_ok |=> core_out_space);
endmodule

// File: tb/mbox_channel_unit_tb.sv
module mbox_channel_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  host_op;
    logic [31:0] host_wdata;
    logic [7:0]  host_mask_clr;
    logic [31:0] host_status;
    logic        host_resp_valid, host_resp_ok;
    logic [2:0]  host_resp_bytes;
    logic [31:0] host_resp_data;
    logic [7:0]  host_irq_mask;
    logic        core_out_push, core_int_push, core_in_pop;
    logic [31:0] core_out_data, core_int_data, core_in_data;
    logic        core_out_space, core_int_space;
    logic [2:0]  core_in_count;
    logic [2:0]  core_ev_mask, core_ev_clr, core_ev_pend;
    logic        core_ev_take, core_ev_count;

    always #2 clk = ~clk;

    mbox_channel_unit u_dut (.*);

    int vectors = 0;
    int errors  = 0;

    // reference model
    bit          m_out_full, m_int_full;
    logic [31:0] m_out_w, m_int_w;
    logic [31:0] m_q [4];
    int          m_cnt;
    logic [2:0]  m_pend;
    bit          m_evc;
    logic [7:0]  m_irq;
    bit          m_rv, m_rok;
    logic [31:0] m_rdata;
    logic [31:0] s;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_out_full = 0; m_int_full = 0; m_out_w = '0; m_int_w = '0;
        for (int i = 0; i < 4; i++) m_q[i] = '0;
        m_cnt = 0; m_pend = '0; m_evc = 0; m_irq = '0;
        m_rv = 0; m_rok = 0; m_rdata = '0;
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R2/R7 status"}, host_status,
            {8'h00, 7'h0, m_int_full, 8'(4 - m_cnt), 7'h0, m_out_full});
        chk({tag, " R3 resp_valid"}, 32'(host_resp_valid), 32'(m_rv));
        chk({tag, " R3 resp_ok"}, 32'(host_resp_ok), 32'(m_rok));
        chk({tag, " R3 resp_bytes"}, 32'(host_resp_bytes), m_rok ? 32'd4 : 32'd0);
        chk({tag, " R4 resp_data"}, host_resp_data, m_rdata);
        chk({tag, " R6 irq_mask"}, 32'(host_irq_mask), 32'(m_irq));
        chk({tag, " R10 out_space"}, 32'(core_out_space), 32'(!m_out_full));
        chk({tag, " R10 int_space"}, 32'(core_int_space), 32'(!m_int_full));
        chk({tag, " R5 in_count"}, 32'(core_in_count), 32'(m_cnt));
        if (m_cnt > 0) chk({tag, " R11 in_head"}, core_in_data, m_q[0]);
        chk({tag, " R8 ev_pend"}, 32'(core_ev_pend), 32'(m_pend));
        chk({tag, " R9 ev_count"}, 32'(core_ev_count), 32'(m_evc));
    endtask

    task automatic model_step();
        int  c0;
        bit  rd_out_ok, rd_int_ok, wr_ok, pop_ok, fire;
        logic [2:0] raise;
        c0        = m_cnt;
        rd_out_ok = (host_op == 2'd1) && m_out_full;
        rd_int_ok = (host_op == 2'd2) && m_int_full;
        wr_ok     = (host_op == 2'd3) && (c0 < 4);
        pop_ok    = core_in_pop && (c0 > 0);
        m_rv      = (host_op != 2'd0);
        m_rok     = rd_out_ok | rd_int_ok | wr_ok;
        m_rdata   = rd_out_ok ? m_out_w : (rd_int_ok ? m_int_w : 32'h0);
        raise     = {wr_ok, rd_int_ok, rd_out_ok};
        fire      = !m_evc && ((raise & ~m_pend & core_ev_mask) != 3'b0);
        m_evc     = fire ? 1'b1 : (core_ev_take ? 1'b0 : m_evc);
        m_pend    = (m_pend & ~core_ev_clr) | raise;
        m_irq     = m_irq & ~host_mask_clr;
        if (host_op == 2'd2 && !m_int_full) m_irq[0] = 1'b1;
        if (host_op == 2'd3 && c0 == 4)     m_irq[4] = 1'b1;
        if (rd_out_ok) m_out_full = 0;
        else if (core_out_push && !m_out_full) begin m_out_full = 1; m_out_w = core_out_data; end
        if (rd_int_ok) m_int_full = 0;
        else if (core_int_push && !m_int_full) begin m_int_full = 1; m_int_w = core_int_data; end
        if (pop_ok) begin
            for (int i = 0; i < 3; i++) m_q[i] = m_q[i+1];
            m_q[3] = '0;
            m_cnt--;
        end
        if (wr_ok) begin m_q[m_cnt] = host_wdata; m_cnt++; end
    endtask

    task automatic idle_inputs();
        host_op = 2'd0; host_wdata = '0; host_mask_clr = '0;
        core_out_push = 0; core_out_data = '0; core_int_push = 0; core_int_data = '0;
        core_in_pop = 0; core_ev_mask = '0; core_ev_clr = '0; core_ev_take = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        s = 32'h1357_9bdf;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(negedge clk);
        // R1: reset state, status reads 0x00000400
        chk("R1 reset status", host_status, 32'h0000_0400);
        check_all("R1");
        for (int cyc = 0; cyc < 6000; cyc++) begin
            bit fill;
            s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
            fill = (cyc % 64) < 32;
            if (cyc == 3000) begin
                rst = 1'b1;
                @(negedge clk);
                rst = 1'b0;
                model_reset();
                check_all("R1 midrun");
                continue;
            end
            host_op       = (fill && s[3:2] != 2'b00) ? 2'd3 : s[1:0];
            host_wdata    = s ^ 32'hA5A5_0000 ^ 32'(cyc);
            host_mask_clr = (s[20] & s[21]) ? s[29:22] : 8'h00;
            core_out_push = s[7] & s[8];
            core_out_data = {s[15:0], s[31:16]};
            core_int_push = s[9] & s[5];
            core_int_data = ~s;
            core_in_pop   = fill ? (s[4] & s[5] & s[6]) : (s[4] | s[5]);
            if (cyc % 16 == 0) core_ev_mask = s[12:10];
            core_ev_clr   = (s[16] & s[17]) ? s[15:13] : 3'b000;
            core_ev_take  = s[18] & s[19];
            model_step();
            @(negedge clk);
            check_all("sweep");
        end
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule